// File: doc/BRIEF.md
# Eight-Function Integer ALU with Signed-Direction Shift

This block is a purely combinational arithmetic and logic unit for a small register-machine datapath. It takes two operands and a 3-bit function select, and it returns one result word in the same cycle. The two operands are normally the second and third register fields of an instruction, and the result goes back to the first register field. The unit holds no state and has no clock.

Seven of the functions are conventional: wrapping add and subtract, low-half multiply, signed less-than, and three bitwise operations. The eighth is a single shift whose direction comes from the sign of the second operand. A positive amount moves the first operand toward the most significant bit. A negative amount moves it toward the least significant bit, filling with zeros. An amount whose magnitude reaches the word width clears the result.

The word width and the multiplier construction are parameters. The subtractor is shared by the subtract and compare functions.

Top module: `octal_alu`

## Requirements
- R1: With `op_sel` = 0 the result is `opnd_a + opnd_b`, truncated to WIDTH bits.
- R2: With `op_sel` = 1 the result is `opnd_a - opnd_b`, truncated to WIDTH bits.
- R3: With `op_sel` = 2 the result is the low WIDTH bits of the unsigned product `opnd_a * opnd_b`.
- R4: With `op_sel` = 3 the result is 1 when `opnd_a` is less than `opnd_b`, both read as two's complement, and 0 otherwise. All upper bits are 0.
- R5: With `op_sel` = 4, 5 and 6 the result is the bitwise AND, OR and XOR of the operands, in that order.
- R6: With `op_sel` = 7 and `opnd_b` read as a signed value from 1 to WIDTH-1, the result is `opnd_a` shifted toward the MSB by that many bits, with zeros entering at bit 0.
- R7: With `op_sel` = 7 and `opnd_b` read as a signed value from -1 to -(WIDTH-1), the result is `opnd_a` shifted logically toward the LSB by `-opnd_b` bits, with zeros entering at the MSB.
- R8: With `op_sel` = 7 and `opnd_b` = 0 the result equals `opnd_a`.
- R9: With `op_sel` = 7 and a signed `opnd_b` of at least WIDTH or at most -WIDTH, the result is 0. This includes the most negative value.
- R10: The result follows any change of the inputs without a clock edge, and it depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Function select, encoded as in R1 to R9 |
| opnd_a | input | WIDTH | First operand (minuend, multiplicand, value to shift) |
| opnd_b | input | WIDTH | Second operand; for function 7, a signed shift amount |
| result | output | WIDTH | Function output |

## Verification
The embedded checks are immediate assertions on settled combinational values. They assume that every input bit is a defined 0 or 1 and that the inputs hold steady while the checks are evaluated. The bench never drives X or Z. It changes the inputs only once per clock period and reads the result half a period later. The random stimulus draws the shift amount for function 7 mostly from a band just beyond ±WIDTH, so that the zero-result boundary, the direction flip and the zero amount are all hit often. Directed vectors add the extreme values and the most negative amount.

// File: rtl/octal_alu_pkg.sv
package octal_alu_pkg;

   typedef enum logic [2:0] {
      FN_ADD = 3'd0,
      FN_SUB = 3'd1,
      FN_MUL = 3'd2,
      FN_SLT = 3'd3,
      FN_AND = 3'd4,
      FN_OR  = 3'd5,
      FN_XOR = 3'd6,
      FN_SHF = 3'd7
   } alu_fn_e;

   localparam int MUL_OPERATOR = 0;
   localparam int MUL_ARRAY    = 1;

endpackage

// File: rtl/octal_alu_addsub.sv
module octal_alu_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         do_sub,
   output logic [W-1:0] sum,
   output logic         less
);

   logic [W-1:0] b_eff;
   logic [W:0]   full;
   logic         ovf;

   if (W < 2) begin : g_bad_width
      $error("octal_alu_addsub: W must be at least 2");
   end

   assign b_eff = do_sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
   assign sum   = full[W-1:0];
   assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   assign less  = sum[W-1] ^ ovf;

   always_comb begin
      // R2
      if (do_sub) begin
         sub_inverse_chk: assert ((sum + b) == a);
      end
   end

endmodule

// File: rtl/octal_alu_mul.sv
module octal_alu_mul #(
   parameter int W     = 16,
   parameter int STYLE = octal_alu_pkg::MUL_OPERATOR
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prod
);

   if (STYLE != octal_alu_pkg::MUL_OPERATOR && STYLE != octal_alu_pkg::MUL_ARRAY) begin : g_bad_style
      $error("octal_alu_mul: unknown STYLE");
   end

   if (STYLE == octal_alu_pkg::MUL_ARRAY) begin : g_array
      logic [W-1:0] acc [0:W];
      assign acc[0] = '0;
      for (genvar i = 0; i < W; i++) begin : g_row
         assign acc[i+1] = acc[i] + (b[i] ? (a << i) : {W{1'b0}});
      end
      assign prod = acc[W];
   end else begin : g_operator
      assign prod = a * b;
   end

   always_comb begin
      // R3
      mul_parity_chk: assert (prod[0] == (a[0] & b[0]));
      // R3
      if (b == {{(W-1){1'b0}}, 1'b1}) begin
         mul_identity_chk: assert (prod == a);
      end
   end

endmodule

// File: rtl/octal_alu_shift.sv
module octal_alu_shift #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] amt,
   output logic [W-1:0] y
);

   localparam int SW = (W > 1) ? $clog2(W) : 1;
   localparam logic [W:0] LIMIT = W;

   logic         neg;
   logic [W:0]   mag;
   logic         too_far;
   logic [W-1:0] src;
   logic [W-1:0] rev_in;
   logic [W-1:0] rev_out;
   logic [W-1:0] stg [0:SW];

   if (W < 2) begin : g_bad_width
      $error("octal_alu_shift: W must be at least 2");
   end

   assign neg     = amt[W-1];
   assign mag     = neg ? ({1'b0, ~amt} + {{W{1'b0}}, 1'b1}) : {1'b0, amt};
   assign too_far = (mag >= LIMIT);

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev_in[i]  = a[W-1-i];
      assign rev_out[i] = stg[SW][W-1-i];
   end

   assign src    = neg ? rev_in : a;
   assign stg[0] = src;

   for (genvar k = 0; k < SW; k++) begin : g_stage
      assign stg[k+1] = mag[k] ? (stg[k] << (1 << k)) : stg[k];
   end

   assign y = too_far ? {W{1'b0}} : (neg ? rev_out : stg[SW]);

   always_comb begin
      // R8
      if (amt == {W{1'b0}}) begin
         shf_zero_amt_chk: assert (y == a);
      end
      // R6
      if (!neg && amt != {W{1'b0}}) begin
         shf_left_lsb_chk: assert (y[0] == 1'b0);
      end
      // R7
      if (neg) begin
         shf_right_msb_chk: assert (y[W-1] == 1'b0);
      end
   end

endmodule

// File: rtl/octal_alu.sv
module octal_alu #(
   parameter int WIDTH     = 16,
   parameter int MUL_STYLE = octal_alu_pkg::MUL_OPERATOR
) (
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result
);

   import octal_alu_pkg::*;

   alu_fn_e          fn;
   logic             do_sub;
   logic [WIDTH-1:0] as_out;
   logic             as_less;
   logic [WIDTH-1:0] mul_out;
   logic [WIDTH-1:0] shf_out;

   if (WIDTH < 4) begin : g_bad_width
      $error("octal_alu: WIDTH must be at least 4");
   end

   assign fn     = alu_fn_e'(op_sel);
   assign do_sub = (fn == FN_SUB) || (fn == FN_SLT);

   octal_alu_addsub #(.W(WIDTH)) i_addsub (
      .a      (opnd_a),
      .b      (opnd_b),
      .do_sub (do_sub),
      .sum    (as_out),
      .less   (as_less)
   );

   octal_alu_mul #(.W(WIDTH), .STYLE(MUL_STYLE)) i_mul (
      .a    (opnd_a),
      .b    (opnd_b),
      .prod (mul_out)
   );

   octal_alu_shift #(.W(WIDTH)) i_shift (
      .a   (opnd_a),
      .amt (opnd_b),
      .y   (shf_out)
   );

   always_comb begin
      unique case (fn)
         FN_ADD, FN_SUB: result = as_out;
         FN_MUL:         result = mul_out;
         FN_SLT:         result = {{(WIDTH-1){1'b0}}, as_less};
         FN_AND:         result = opnd_a & opnd_b;
         FN_OR:          result = opnd_a | opnd_b;
         FN_XOR:         result = opnd_a ^ opnd_b;
         FN_SHF:         result = shf_out;
         default:        result = '0;
      endcase
   end

   always_comb begin
      // R1
      if (fn == FN_ADD) begin
         add_inverse_chk: assert ((result - opnd_b) == opnd_a);
      end
      // R4
      if (fn == FN_SLT) begin
         slt_signed_chk: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)) &&
                                 result[WIDTH-1:1] == '0);
      end
      // R5
      if (fn == FN_AND) begin
         and_subset_chk: assert ((result & ~opnd_a) == '0 && (result & ~opnd_b) == '0);
      end
      // R5
      if (fn == FN_OR) begin
         or_superset_chk: assert ((result & opnd_a) == opnd_a && (result & opnd_b) == opnd_b);
      end
      // R5
      if (fn == FN_XOR) begin
         xor_inverse_chk: assert ((result ^ opnd_b) == opnd_a);
      end
      // R9
      if (fn == FN_SHF && ($signed(opnd_b) >= WIDTH || $signed(opnd_b) <= -WIDTH)) begin
         shf_range_zero_chk: assert (result == '0);
      end
   end

endmodule

// File: tb/test_octal_alu.sv
module test_octal_alu;

   localparam int  W          = 16;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic [2:0]   op_sel;
   logic [W-1:0] opnd_a;
   logic [W-1:0] opnd_b;
   logic [W-1:0] result;

   int vectors     = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   octal_alu #(.WIDTH(W)) i_octal_alu (
      .op_sel (op_sel),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .result (result)
   );

   function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
      logic [2*W-1:0] p;
      int sb;
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: begin p = {{W{1'b0}}, a} * {{W{1'b0}}, b}; return p[W-1:0]; end
         3'd3: return ($signed(a) < $signed(b)) ? {{(W-1){1'b0}}, 1'b1} : {W{1'b0}};
         3'd4: return a & b;
         3'd5: return a | b;
         3'd6: return a ^ b;
         default: begin
            sb = int'($signed(b));
            if (sb >= W || sb <= -W) return '0;
            if (sb >= 0) return a << sb;
            return a >> (-sb);
         end
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] op, input logic [W-1:0] b);
      int sb;
      sb = int'($signed(b));
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4, 3'd5, 3'd6: return "R5";
         default: begin
            if (sb == 0) return "R8";
            if (sb >= W || sb <= -W) return "R9";
            if (sb < 0) return "R7";
            return "R6";
         end
      endcase
   endfunction

   task automatic compare(input string tag, input logic [W-1:0] expv);
      vectors++;
      if (result !== expv) begin
         miscompares++;
         $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                  tag, op_sel, opnd_a, opnd_b, result, expv);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(posedge clk);
      op_sel = op;
      opnd_a = a;
      opnd_b = b;
      @(negedge clk);
      compare(req_of(op, b), model(op, a, b));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      op_sel = 3'd0;
      opnd_a = '0;
      opnd_b = '0;
      void'($urandom(32'd20240611));

      // R10: settled output for zero inputs, before any other stimulus
      @(negedge clk);
      compare("R10", '0);

      // directed corners
      apply(3'd0, 16'hFFFF, 16'h0001);   // R1 wrap
      apply(3'd1, 16'h0000, 16'h0001);   // R2 wrap
      apply(3'd2, 16'h1234, 16'h0100);   // R3 low half
      apply(3'd2, 16'hFFFF, 16'hFFFF);   // R3
      apply(3'd3, 16'h8000, 16'h7FFF);   // R4 signed: 1
      apply(3'd3, 16'h7FFF, 16'h8000);   // R4 signed: 0
      apply(3'd3, 16'h0005, 16'h0005);   // R4 equal: 0
      apply(3'd3, 16'hFFFF, 16'h0000);   // R4 -1 < 0
      apply(3'd4, 16'hF0F0, 16'hFF00);   // R5
      apply(3'd5, 16'hF0F0, 16'h0F0F);   // R5
      apply(3'd6, 16'hAAAA, 16'hFFFF);   // R5
      apply(3'd7, 16'h8001, 16'h0000);   // R8
      apply(3'd7, 16'h8001, 16'h0001);   // R6
      apply(3'd7, 16'h8001, 16'h000F);   // R6 max left
      apply(3'd7, 16'h8001, 16'hFFFF);   // R7 right by 1
      apply(3'd7, 16'hFFFF, 16'hFFF1);   // R7 right by 15
      apply(3'd7, 16'hFFFF, 16'h0010);   // R9 +16
      apply(3'd7, 16'hFFFF, 16'hFFF0);   // R9 -16
      apply(3'd7, 16'hFFFF, 16'h8000);   // R9 most negative
      apply(3'd7, 16'hFFFF, 16'h7FFF);   // R9 most positive

      // R10: change inputs mid-cycle, no clock edge in between
      @(posedge clk);
      op_sel = 3'd0; opnd_a = 16'h0003; opnd_b = 16'h0004;
      #1;
      compare("R10", 16'h0007);
      op_sel = 3'd6;
      #1;
      compare("R10", 16'h0007);
      opnd_b = 16'h0003;
      #1;
      compare("R10", 16'h0000);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [2:0]   rop;
         logic [W-1:0] ra;
         logic [W-1:0] rb;
         rop = 3'($urandom_range(7, 0));
         ra  = W'($urandom);
         rb  = W'($urandom);
         if (rop == 3'd7 && $urandom_range(3, 0) != 0) begin
            int amt;
            amt = int'($urandom_range(40, 0)) - 20;
            rb  = W'(amt);
         end
         apply(rop, ra, rb);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule